// File: doc/BRIEF.md
# Serial Flash / EEPROM Host Command Engine

This block is the host side of a serial-memory port that drives two devices, a flash and an EEPROM, over one shared clock/data pair with a separate chip select for each. Software loads an address holding register (up to three bytes) and a 16-byte data buffer. It then writes a single command word. The command word picks the device, supplies the opcode byte and gives three byte counts: address, dummy and data. It also says whether the data phase transmits or receives. From that one write the engine produces a whole framed transfer and reports completion by dropping its busy flag.

Each phase after the opcode is optional, because its length comes from its byte count. The same frame shape therefore covers opcode-only commands such as a write-enable, a status read with one received byte and no address, addressed reads and writes, and fast reads that use dummy bytes. Received bytes are placed in the data buffer, which software reads once busy is low. Each device has its own clock divider, held in a configuration register. An external write-timer status input must be low before a new command is accepted.

Top module: `spi_host_engine`

## Requirements
- R1: When idle, a cycle with `cmd_we` high, `cmd_en` high, `wr_timer_active` low and `cmd_data_cnt` of at most 16 starts a transfer. `busy` is high from the next cycle until the transfer ends, and it serves as the readable enable bit.
- R2: A frame sends the opcode byte, then `cmd_addr_cnt` (0 to 3) bytes of `addr_in` with the most significant used byte first, then `cmd_dummy_cnt` bytes of 0x00, then `cmd_data_cnt` data bytes. Within each byte the bits go out MSB first.
- R3: A start request whose `cmd_data_cnt` exceeds 16 starts nothing. `cmd_reject` pulses high for exactly one cycle, in the cycle after the request.
- R4: On a write (`cmd_read`=0), data byte d of the frame is `data_out[8d+7:8d]` of the buffer, with byte 0 in bits [7:0].
- R5: On a read (`cmd_read`=1), MOSI is low for the whole data phase. Received byte d is stored in buffer bits [8d+7:8d], and buffer bytes at or above `cmd_data_cnt` keep their value.
- R6: A data count of 0 produces an opcode-only frame (for example 0x06), and a 1-byte read with address count 0 produces a status-read frame (for example 0x05).
- R7: `cmd_dev_sel`=0 selects the flash (`spi_cs_n[0]`) and its divider; 1 selects the EEPROM (`spi_cs_n[1]`) and its divider. With a divider value N, the high and low phases of `spi_sck` each last N+1 clock cycles. After reset the flash divider is 7 and the EEPROM divider is 63.
- R8: The clock runs in mode 0. `spi_sck` is low when idle, MOSI changes only after a falling edge (or at chip-select assertion), and MISO is sampled on the rising edge.
- R9: Only the selected chip select goes low. It falls one half-period before the first rising edge of `spi_sck` and rises one half-period after the last falling edge. Both selects are high whenever `busy` is low.
- R10: A command write is ignored, with no frame and no reject, while `busy` is high, while `wr_timer_active` is high, or when `cmd_en` is low.
- R11: Loads of the address register and the data buffer are ignored while `busy` is high.
- R12: After reset, `busy`, `cmd_reject`, `spi_sck`, `spi_mosi` and `data_out` are 0 and `spi_cs_n` is 2'b11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr_we | input | 1 | Load `addr_in` into the address register |
| addr_in | input | 24 | Address value, the used bytes are the low ones |
| data_we | input | 1 | Load `data_in` into the data buffer |
| data_in | input | 128 | Data buffer load value |
| data_out | output | 128 | Data buffer contents |
| cfg_we | input | 1 | Load both clock dividers |
| cfg_flash_div | input | 7 | Flash divider value |
| cfg_eeprom_div | input | 7 | EEPROM divider value |
| cmd_we | input | 1 | Command register write strobe |
| cmd_en | input | 1 | Enable bit of the command word |
| cmd_dev_sel | input | 1 | 0 flash, 1 EEPROM |
| cmd_opcode | input | 8 | Opcode byte |
| cmd_addr_cnt | input | 2 | Address byte count |
| cmd_dummy_cnt | input | 2 | Dummy byte count |
| cmd_data_cnt | input | 5 | Data byte count |
| cmd_read | input | 1 | 1 receive data, 0 transmit data |
| wr_timer_active | input | 1 | External write timer running; blocks starts |
| busy | output | 1 | Transfer in progress (enable bit readback) |
| cmd_reject | output | 1 | One-cycle pulse for an over-length request |
| spi_sck | output | 1 | Serial clock |
| spi_cs_n | output | 2 | Active-low selects, [0] flash, [1] EEPROM |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |

## Verification
The assertions assume that `spi_miso` only changes while `spi_sck` is low or the selects are high. They also assume that software raises `cmd_we` for one cycle at a time, so each new start is traced back to a single strobe. The bench's device model changes MISO only at a chip-select fall or an `spi_sck` fall, and it drives every register and command strobe for exactly one cycle from the falling clock edge. Command and load strobes raised during a transfer are deliberate and exercise the ignore rules. Both chip selects are also monitored continuously, so that a cycle with both low is counted.

// File: rtl/spi_host_pkg.sv
`timescale 1ns/1ps
package spi_host_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_LOW,
    ST_HIGH,
    ST_HOLD
  } seq_state_t;
endpackage

// File: rtl/spi_sck_timer.sv
`timescale 1ns/1ps
module spi_sck_timer #(
  parameter int DIV_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt_q;

  assign tick = run && (cnt_q == div);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt_q <= '0;
    else if (!run)    cnt_q <= '0;
    else if (tick)    cnt_q <= '0;
    else              cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/spi_frame_mux.sv
`timescale 1ns/1ps
module spi_frame_mux #(
  parameter int ADDR_W     = 24,
  parameter int DATA_BYTES = 16,
  parameter int DUMMY_W    = 2,
  parameter int CNT_W      = 5,
  parameter int ACNT_W     = 2,
  parameter int IDX_W      = 5
) (
  input  logic [IDX_W-1:0]          byte_idx,
  input  logic [7:0]                opcode,
  input  logic [ACNT_W-1:0]         addr_cnt,
  input  logic [DUMMY_W-1:0]        dummy_cnt,
  input  logic [CNT_W-1:0]          data_cnt,
  input  logic                      is_read,
  input  logic [ADDR_W-1:0]         addr,
  input  logic [8*DATA_BYTES-1:0]   wdata,
  output logic [7:0]                tx_byte,
  output logic                      rd_data_byte,
  output logic [$clog2(DATA_BYTES)-1:0] data_idx,
  output logic                      last_byte
);
  localparam int DIDX_W = $clog2(DATA_BYTES);

  logic [IDX_W-1:0] a_end, d_end, f_end, a_sel, d_sel;
  logic [ADDR_W-1:0] a_shift;
  logic [8*DATA_BYTES-1:0] d_shift;

  always_comb begin
    a_end     = IDX_W'(addr_cnt);
    d_end     = a_end + IDX_W'(dummy_cnt);
    f_end     = d_end + IDX_W'(data_cnt);
    a_sel     = a_end - byte_idx;
    d_sel     = byte_idx - d_end - 1'b1;
    data_idx  = DIDX_W'(d_sel);
    a_shift   = addr >> {a_sel, 3'b000};
    d_shift   = wdata >> {data_idx, 3'b000};
    last_byte = (byte_idx == f_end);
    tx_byte      = 8'h00;
    rd_data_byte = 1'b0;
    if (byte_idx == '0)           tx_byte = opcode;
    else if (byte_idx <= a_end)   tx_byte = a_shift[7:0];
    else if (byte_idx <= d_end)   tx_byte = 8'h00;
    else if (is_read)             rd_data_byte = 1'b1;
    else                          tx_byte = d_shift[7:0];
  end
endmodule

// File: rtl/spi_data_buf.sv
`timescale 1ns/1ps
module spi_data_buf #(
  parameter int DATA_BYTES = 16
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           ld_we,
  input  logic [8*DATA_BYTES-1:0]        ld_data,
  input  logic                           cap_we,
  input  logic [$clog2(DATA_BYTES)-1:0]  cap_idx,
  input  logic [7:0]                     cap_byte,
  output logic [8*DATA_BYTES-1:0]        q
);
  localparam int DIDX_W = $clog2(DATA_BYTES);

  for (genvar g = 0; g < DATA_BYTES; g++) begin : g_lane
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        q[8*g +: 8] <= 8'h00;
      else if (ld_we)
        q[8*g +: 8] <= ld_data[8*g +: 8];
      else if (cap_we && (cap_idx == DIDX_W'(g)))
        q[8*g +: 8] <= cap_byte;
    end
  end
endmodule

// File: rtl/spi_host_seq.sv
`timescale 1ns/1ps
module spi_host_seq
  import spi_host_pkg::*;
#(
  parameter int DIV_W      = 7,
  parameter int CNT_W      = 5,
  parameter int DUMMY_W    = 2,
  parameter int ACNT_W     = 2,
  parameter int IDX_W      = 5,
  parameter int DATA_BYTES = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cmd_we,
  input  logic               cmd_en,
  input  logic               cmd_dev_sel,
  input  logic [7:0]         cmd_opcode,
  input  logic [ACNT_W-1:0]  cmd_addr_cnt,
  input  logic [DUMMY_W-1:0] cmd_dummy_cnt,
  input  logic [CNT_W-1:0]   cmd_data_cnt,
  input  logic               cmd_read,
  input  logic               wr_timer_active,
  input  logic [DIV_W-1:0]   flash_div,
  input  logic [DIV_W-1:0]   ee_div,
  input  logic               tick,
  input  logic [7:0]         tx_byte,
  input  logic               rd_data_byte,
  input  logic               last_byte,
  input  logic               spi_miso,
  output logic               busy,
  output logic               cmd_reject,
  output logic               spi_sck,
  output logic [1:0]         spi_cs_n,
  output logic               spi_mosi,
  output logic [DIV_W-1:0]   div_q,
  output logic [IDX_W-1:0]   byte_idx,
  output logic [7:0]         q_opcode,
  output logic [ACNT_W-1:0]  q_addr_cnt,
  output logic [DUMMY_W-1:0] q_dummy_cnt,
  output logic [CNT_W-1:0]   q_data_cnt,
  output logic               q_read,
  output logic               cap_we,
  output logic [7:0]         cap_byte
);
  seq_state_t state_q;
  logic [2:0] bit_idx;
  logic [7:0] rx_sh;
  logic       dev_q;
  logic       start_req, too_long, in_frame;

  assign start_req = (state_q == ST_IDLE) && cmd_we && cmd_en && !wr_timer_active;
  assign too_long  = cmd_data_cnt > CNT_W'(DATA_BYTES);
  assign busy      = (state_q != ST_IDLE);
  assign in_frame  = (state_q == ST_SETUP) || (state_q == ST_LOW) || (state_q == ST_HIGH);
  assign spi_sck   = (state_q == ST_HIGH);
  assign spi_cs_n  = !busy ? 2'b11 : (dev_q ? 2'b01 : 2'b10);
  assign spi_mosi  = in_frame ? tx_byte[bit_idx] : 1'b0;
  assign cap_we    = (state_q == ST_HIGH) && tick && (bit_idx == 3'd0) && rd_data_byte;
  assign cap_byte  = rx_sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= ST_IDLE;
      bit_idx     <= 3'd7;
      rx_sh       <= 8'h00;
      dev_q       <= 1'b0;
      div_q       <= '0;
      byte_idx    <= '0;
      q_opcode    <= 8'h00;
      q_addr_cnt  <= '0;
      q_dummy_cnt <= '0;
      q_data_cnt  <= '0;
      q_read      <= 1'b0;
      cmd_reject  <= 1'b0;
    end else begin
      cmd_reject <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (start_req) begin
            if (too_long) begin
              cmd_reject <= 1'b1;
            end else begin
              state_q     <= ST_SETUP;
              dev_q       <= cmd_dev_sel;
              div_q       <= cmd_dev_sel ? ee_div : flash_div;
              byte_idx    <= '0;
              bit_idx     <= 3'd7;
              q_opcode    <= cmd_opcode;
              q_addr_cnt  <= cmd_addr_cnt;
              q_dummy_cnt <= cmd_dummy_cnt;
              q_data_cnt  <= cmd_data_cnt;
              q_read      <= cmd_read;
            end
          end
        end
        ST_SETUP, ST_LOW: begin
          if (tick) begin
            state_q <= ST_HIGH;
            rx_sh   <= {rx_sh[6:0], spi_miso};
          end
        end
        ST_HIGH: begin
          if (tick) begin
            if (bit_idx == 3'd0) begin
              if (last_byte) begin
                state_q <= ST_HOLD;
              end else begin
                state_q  <= ST_LOW;
                byte_idx <= byte_idx + 1'b1;
                bit_idx  <= 3'd7;
              end
            end else begin
              state_q <= ST_LOW;
              bit_idx <= bit_idx - 1'b1;
            end
          end
        end
        ST_HOLD: begin
          if (tick) state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/spi_host_engine.sv
`timescale 1ns/1ps
module spi_host_engine #(
  parameter int ADDR_W     = 24,
  parameter int DATA_BYTES = 16,
  parameter int DUMMY_W    = 2,
  parameter int CNT_W      = 5,
  parameter int DIV_W      = 7,
  parameter int FLASH_DIV_RST = 7,
  parameter int EE_DIV_RST    = 63
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    addr_we,
  input  logic [ADDR_W-1:0]       addr_in,
  input  logic                    data_we,
  input  logic [8*DATA_BYTES-1:0] data_in,
  output logic [8*DATA_BYTES-1:0] data_out,
  input  logic                    cfg_we,
  input  logic [DIV_W-1:0]        cfg_flash_div,
  input  logic [DIV_W-1:0]        cfg_eeprom_div,
  input  logic                    cmd_we,
  input  logic                    cmd_en,
  input  logic                    cmd_dev_sel,
  input  logic [7:0]              cmd_opcode,
  input  logic [$clog2(ADDR_W/8+1)-1:0] cmd_addr_cnt,
  input  logic [DUMMY_W-1:0]      cmd_dummy_cnt,
  input  logic [CNT_W-1:0]        cmd_data_cnt,
  input  logic                    cmd_read,
  input  logic                    wr_timer_active,
  output logic                    busy,
  output logic                    cmd_reject,
  output logic                    spi_sck,
  output logic [1:0]              spi_cs_n,
  output logic                    spi_mosi,
  input  logic                    spi_miso
);
  localparam int ADDR_BYTES = ADDR_W / 8;
  localparam int ACNT_W     = $clog2(ADDR_BYTES + 1);
  localparam int DIDX_W     = $clog2(DATA_BYTES);
  localparam int IDX_W      = $clog2(ADDR_BYTES + (1 << DUMMY_W) + DATA_BYTES + 1);

  logic [ADDR_W-1:0] addr_q;
  logic [DIV_W-1:0]  flash_div_q, ee_div_q, div_q;
  logic              tick, rd_data_byte, last_byte, cap_we, q_read;
  logic [7:0]        tx_byte, cap_byte, q_opcode;
  logic [IDX_W-1:0]  byte_idx;
  logic [ACNT_W-1:0] q_addr_cnt;
  logic [DUMMY_W-1:0] q_dummy_cnt;
  logic [CNT_W-1:0]  q_data_cnt;
  logic [DIDX_W-1:0] data_idx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q      <= '0;
      flash_div_q <= DIV_W'(FLASH_DIV_RST);
      ee_div_q    <= DIV_W'(EE_DIV_RST);
    end else begin
      if (addr_we && !busy) addr_q <= addr_in;
      if (cfg_we) begin
        flash_div_q <= cfg_flash_div;
        ee_div_q    <= cfg_eeprom_div;
      end
    end
  end

  spi_sck_timer #(.DIV_W(DIV_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .run(busy), .div(div_q), .tick(tick)
  );

  spi_host_seq #(
    .DIV_W(DIV_W), .CNT_W(CNT_W), .DUMMY_W(DUMMY_W), .ACNT_W(ACNT_W),
    .IDX_W(IDX_W), .DATA_BYTES(DATA_BYTES)
  ) u_seq (
    .clk(clk), .rst_n(rst_n),
    .cmd_we(cmd_we), .cmd_en(cmd_en), .cmd_dev_sel(cmd_dev_sel),
    .cmd_opcode(cmd_opcode), .cmd_addr_cnt(cmd_addr_cnt),
    .cmd_dummy_cnt(cmd_dummy_cnt), .cmd_data_cnt(cmd_data_cnt),
    .cmd_read(cmd_read), .wr_timer_active(wr_timer_active),
    .flash_div(flash_div_q), .ee_div(ee_div_q),
    .tick(tick), .tx_byte(tx_byte), .rd_data_byte(rd_data_byte),
    .last_byte(last_byte), .spi_miso(spi_miso),
    .busy(busy), .cmd_reject(cmd_reject), .spi_sck(spi_sck),
    .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi), .div_q(div_q),
    .byte_idx(byte_idx), .q_opcode(q_opcode), .q_addr_cnt(q_addr_cnt),
    .q_dummy_cnt(q_dummy_cnt), .q_data_cnt(q_data_cnt), .q_read(q_read),
    .cap_we(cap_we), .cap_byte(cap_byte)
  );

  spi_frame_mux #(
    .ADDR_W(ADDR_W), .DATA_BYTES(DATA_BYTES), .DUMMY_W(DUMMY_W),
    .CNT_W(CNT_W), .ACNT_W(ACNT_W), .IDX_W(IDX_W)
  ) u_mux (
    .byte_idx(byte_idx), .opcode(q_opcode), .addr_cnt(q_addr_cnt),
    .dummy_cnt(q_dummy_cnt), .data_cnt(q_data_cnt), .is_read(q_read),
    .addr(addr_q), .wdata(data_out), .tx_byte(tx_byte),
    .rd_data_byte(rd_data_byte), .data_idx(data_idx), .last_byte(last_byte)
  );

  spi_data_buf #(.DATA_BYTES(DATA_BYTES)) u_buf (
    .clk(clk), .rst_n(rst_n), .ld_we(data_we && !busy), .ld_data(data_in),
    .cap_we(cap_we), .cap_idx(data_idx), .cap_byte(cap_byte), .q(data_out)
  );
endmodule

// File: rtl/spi_host_engine_chk.sv
`timescale 1ns/1ps
module spi_host_engine_chk #(
  parameter int DATA_BYTES = 16,
  parameter int CNT_W      = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cmd_we,
  input logic             cmd_en,
  input logic [CNT_W-1:0] cmd_data_cnt,
  input logic             wr_timer_active,
  input logic             busy,
  input logic             cmd_reject,
  input logic             spi_sck,
  input logic [1:0]       spi_cs_n
);
  // R1
  start_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(cmd_we && cmd_en && !wr_timer_active));

  // R3
  reject_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_reject |-> $past(cmd_we && cmd_en && (cmd_data_cnt > CNT_W'(DATA_BYTES))));

  // R3
  reject_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_reject |-> !busy);

  // R9
  cs_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(~spi_cs_n) <= 1);

  // R9
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (spi_cs_n == 2'b11) && !spi_sck);

  // R9
  cs_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(spi_cs_n));

  // R8
  sck_framed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    spi_sck |-> (spi_cs_n != 2'b11));
endmodule

bind spi_host_engine spi_host_engine_chk #(
  .DATA_BYTES(DATA_BYTES), .CNT_W(CNT_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_we(cmd_we), .cmd_en(cmd_en),
  .cmd_data_cnt(cmd_data_cnt), .wr_timer_active(wr_timer_active),
  .busy(busy), .cmd_reject(cmd_reject), .spi_sck(spi_sck),
  .spi_cs_n(spi_cs_n)
);

// File: tb/test_spi_host_engine.sv
`timescale 1ns/1ps
module test_spi_host_engine;
  localparam int NV = 7;
  // {rd, dev, opcode, addr_cnt, dummy_cnt, data_cnt, addr}
  localparam logic [42:0] VECS [NV] = '{
    {1'b0, 1'b0, 8'h06, 2'd0, 2'd0, 5'd0,  24'h000000},
    {1'b1, 1'b1, 8'h05, 2'd0, 2'd0, 5'd1,  24'h000000},
    {1'b1, 1'b0, 8'h03, 2'd3, 2'd0, 5'd4,  24'h0A1B2C},
    {1'b0, 1'b1, 8'h02, 2'd2, 2'd0, 5'd16, 24'h0001F0},
    {1'b1, 1'b0, 8'h0B, 2'd3, 2'd1, 5'd16, 24'h123456},
    {1'b0, 1'b1, 8'h0A, 2'd1, 2'd2, 5'd5,  24'h0000C3},
    {1'b1, 1'b1, 8'h03, 2'd2, 2'd3, 5'd2,  24'h00ABCD}
  };

  logic clk = 0, rst_n = 0;
  logic addr_we = 0, data_we = 0, cfg_we = 0, cmd_we = 0, cmd_en = 0;
  logic [23:0] addr_in = 0;
  logic [127:0] data_in = 0, data_out;
  logic [6:0] cfg_flash_div = 0, cfg_eeprom_div = 0;
  logic cmd_dev_sel = 0, cmd_read = 0, wr_timer_active = 0;
  logic [7:0] cmd_opcode = 0;
  logic [1:0] cmd_addr_cnt = 0, cmd_dummy_cnt = 0;
  logic [4:0] cmd_data_cnt = 0;
  logic busy, cmd_reject, spi_sck, spi_mosi;
  logic [1:0] spi_cs_n;
  logic spi_miso = 0;

  always #10 clk = ~clk;

  spi_host_engine i_spi_host_engine (
    .clk(clk), .rst_n(rst_n), .addr_we(addr_we), .addr_in(addr_in),
    .data_we(data_we), .data_in(data_in), .data_out(data_out),
    .cfg_we(cfg_we), .cfg_flash_div(cfg_flash_div), .cfg_eeprom_div(cfg_eeprom_div),
    .cmd_we(cmd_we), .cmd_en(cmd_en), .cmd_dev_sel(cmd_dev_sel),
    .cmd_opcode(cmd_opcode), .cmd_addr_cnt(cmd_addr_cnt),
    .cmd_dummy_cnt(cmd_dummy_cnt), .cmd_data_cnt(cmd_data_cnt),
    .cmd_read(cmd_read), .wr_timer_active(wr_timer_active),
    .busy(busy), .cmd_reject(cmd_reject), .spi_sck(spi_sck),
    .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi), .spi_miso(spi_miso)
  );

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // ---------------- device model ----------------
  wire frame_n = &spi_cs_n;
  logic [7:0] mosi_bytes [32];
  logic [7:0] sh;
  int bitn = 0, nrise = 0, per_err = 0, cs_falls = 0, both_low = 0;
  logic [1:0] cs_seen;
  time half_t = 20, t_csfall, t_csrise, t_lastfall, t_lastrise;

  function automatic logic [7:0] resp(input int k);
    return 8'hA0 ^ 8'(k);
  endfunction

  always @(negedge frame_n) begin
    cs_falls++;
    bitn = 0; nrise = 0; per_err = 0;
    t_csfall = $time;
    cs_seen = spi_cs_n;
    spi_miso = resp(0)[7];
  end
  always @(posedge frame_n) t_csrise = $time;
  always @(spi_cs_n) if (spi_cs_n == 2'b00) both_low++;

  always @(posedge spi_sck) begin
    if (nrise == 0) begin
      if ($time - t_csfall != half_t) per_err++;
    end else if ($time - t_lastrise != 2 * half_t) per_err++;
    t_lastrise = $time;
    nrise++;
    sh = {sh[6:0], spi_mosi};
    bitn++;
    if (bitn % 8 == 0 && bitn / 8 <= 32) mosi_bytes[bitn/8-1] = sh;
  end
  always @(negedge spi_sck) begin
    t_lastfall = $time;
    spi_miso = resp(bitn / 8)[7 - (bitn % 8)];
  end

  // ---------------- helpers ----------------
  logic [6:0] fl_div = 7, ee_div = 63;

  function automatic logic [7:0] wpat(input int i, input int d);
    return 8'(d * 17 + i * 29 + 5);
  endfunction

  task automatic load_data(input logic [127:0] v);
    @(negedge clk); data_we = 1; data_in = v;
    @(negedge clk); data_we = 0;
  endtask

  task automatic load_addr(input logic [23:0] v);
    @(negedge clk); addr_we = 1; addr_in = v;
    @(negedge clk); addr_we = 0;
  endtask

  task automatic issue(input bit en, input bit rd, input bit dev, input logic [7:0] op,
                       input logic [1:0] ac, input logic [1:0] dc, input logic [4:0] n);
    half_t = 20 * ((dev ? int'(ee_div) : int'(fl_div)) + 1);
    @(negedge clk);
    cmd_we = 1; cmd_en = en; cmd_read = rd; cmd_dev_sel = dev; cmd_opcode = op;
    cmd_addr_cnt = ac; cmd_dummy_cnt = dc; cmd_data_cnt = n;
    @(negedge clk);
    cmd_we = 0; cmd_en = 0;
  endtask

  task automatic wait_idle;
    int lim = 0;
    while (busy && lim < 20000) begin @(negedge clk); lim++; end
  endtask

  // check a completed frame against the command
  task automatic check_frame(input string tag, input bit rd, input bit dev, input logic [7:0] op,
                             input int ac, input int dc, input int n,
                             input logic [23:0] av, input logic [127:0] wd);
    int nb = 1 + ac + dc + n;
    bit ok = 1;
    logic [7:0] e;
    chk(bitn == 8 * nb, {tag, " R2 bit count"}, 128'(bitn), 128'(8 * nb));
    for (int k = 0; k < nb; k++) begin
      if (k == 0) e = op;
      else if (k <= ac) e = av[8*(ac-k) +: 8];
      else if (k <= ac + dc) e = 8'h00;
      else if (rd) e = 8'h00;
      else e = wd[8*(k-1-ac-dc) +: 8];
      if (mosi_bytes[k] !== e) begin
        ok = 0;
        $display("FAIL %s R2/R4/R5 byte %0d actual=%0h expected=%0h", tag, k, mosi_bytes[k], e);
      end
    end
    n_chk++; if (!ok) n_bad++;
    chk(cs_seen == (dev ? 2'b01 : 2'b10), {tag, " R7 select"}, 128'(cs_seen), 128'(dev ? 2'b01 : 2'b10));
    chk(per_err == 0, {tag, " R7/R8 sck timing"}, 128'(per_err), 128'(0));
    chk(t_csrise - t_lastfall == half_t, {tag, " R9 select hold"}, 128'(t_csrise - t_lastfall), 128'(half_t));
    chk(spi_cs_n == 2'b11 && !spi_sck, {tag, " R9 idle selects"}, 128'(spi_cs_n), 128'(3));
  endtask

  // ---------------- main ----------------
  initial begin
    logic [127:0] wd, exp_d;
    int prev_falls;
    for (int c = 0; c < 10; c++) begin
      @(negedge clk);
      if (c == 3) begin
        // R12 reset state while held
        chk(busy == 0 && cmd_reject == 0 && spi_sck == 0 && spi_mosi == 0,
            "R12 reset controls", 128'({busy, cmd_reject, spi_sck, spi_mosi}), 128'(0));
        chk(spi_cs_n == 2'b11, "R12 reset selects", 128'(spi_cs_n), 128'(3));
        chk(data_out == 0, "R12 reset buffer", data_out, 128'(0));
      end
    end
    rst_n = 1;
    repeat (2) @(negedge clk);

    // R7 reset divider (EEPROM 63) with an opcode-only frame, R6
    load_addr(24'h000000);
    issue(1, 0, 1, 8'h06, 0, 0, 0);
    chk(busy == 1, "R1 busy after start", 128'(busy), 128'(1));
    wait_idle();
    check_frame("reset-div R6 R7", 0, 1, 8'h06, 0, 0, 0, 24'h0, 128'h0);

    // R7 reset flash divider 7
    issue(1, 1, 0, 8'h05, 0, 0, 1);
    wait_idle();
    check_frame("reset-div flash R7", 1, 0, 8'h05, 0, 0, 1, 24'h0, 128'h0);

    // new dividers
    @(negedge clk); cfg_we = 1; cfg_flash_div = 1; cfg_eeprom_div = 3;
    @(negedge clk); cfg_we = 0; fl_div = 1; ee_div = 3;

    // vector table
    for (int i = 0; i < NV; i++) begin
      logic [42:0] v = VECS[i];
      bit rd = v[42], dev = v[41];
      logic [7:0] op = v[40:33];
      int ac = int'(v[32:31]), dc = int'(v[30:29]), n = int'(v[28:24]);
      logic [23:0] av = v[23:0];
      string tag = $sformatf("vec%0d", i);
      for (int d = 0; d < 16; d++) wd[8*d +: 8] = wpat(i, d);
      load_data(wd);
      load_addr(av);
      issue(1, rd, dev, op, v[32:31], v[30:29], v[28:24]);
      wait_idle();
      check_frame(tag, rd, dev, op, ac, dc, n, av, wd);
      exp_d = wd;
      if (rd) for (int d = 0; d < n; d++) exp_d[8*d +: 8] = resp(1 + ac + dc + d);
      chk(data_out == exp_d, {tag, rd ? " R5 read buffer" : " R4 buffer kept"}, data_out, exp_d);
    end
    chk(both_low == 0, "R9 both selects low", 128'(both_low), 128'(0));

    // R3 over-length request
    prev_falls = cs_falls;
    issue(1, 1, 0, 8'h03, 0, 0, 17);
    chk(cmd_reject == 1, "R3 reject pulse", 128'(cmd_reject), 128'(1));
    chk(busy == 0, "R3 no start", 128'(busy), 128'(0));
    @(negedge clk);
    chk(cmd_reject == 0, "R3 pulse one cycle", 128'(cmd_reject), 128'(0));
    repeat (5) @(negedge clk);
    chk(cs_falls == prev_falls, "R3 no frame", 128'(cs_falls), 128'(prev_falls));

    // R10 write timer active
    wr_timer_active = 1;
    issue(1, 0, 0, 8'h06, 0, 0, 0);
    chk(busy == 0 && cmd_reject == 0, "R10 timer blocks", 128'({busy, cmd_reject}), 128'(0));
    @(negedge clk); wr_timer_active = 0;
    repeat (5) @(negedge clk);
    chk(busy == 0 && cs_falls == prev_falls, "R10 timer no later start", 128'(cs_falls), 128'(prev_falls));

    // R10 enable bit low
    issue(0, 0, 0, 8'h06, 0, 0, 0);
    repeat (3) @(negedge clk);
    chk(busy == 0 && cs_falls == prev_falls, "R10 enable low", 128'(cs_falls), 128'(prev_falls));

    // R10 + R11 strobes during a transfer
    for (int d = 0; d < 16; d++) wd[8*d +: 8] = 8'(8'h30 + d);
    load_data(wd);
    load_addr(24'h445566);
    issue(1, 0, 0, 8'h02, 3, 0, 8);
    repeat (10) @(negedge clk);
    data_we = 1; data_in = ~wd; addr_we = 1; addr_in = 24'h778899;
    cmd_we = 1; cmd_en = 1; cmd_opcode = 8'h9F; cmd_dev_sel = 1; cmd_data_cnt = 17;
    @(negedge clk);
    data_we = 0; addr_we = 0; cmd_we = 0; cmd_en = 0;
    chk(cmd_reject == 0, "R10 no reject while busy", 128'(cmd_reject), 128'(0));
    wait_idle();
    check_frame("busy-strobe R10", 0, 0, 8'h02, 3, 0, 8, 24'h445566, wd);
    chk(cs_falls == prev_falls + 1, "R10 single frame", 128'(cs_falls), 128'(prev_falls + 1));
    chk(data_out == wd, "R11 buffer load ignored", data_out, wd);
    issue(1, 0, 0, 8'h03, 3, 0, 0);
    wait_idle();
    check_frame("addr-kept R11", 0, 0, 8'h03, 3, 0, 0, 24'h445566, wd);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule